// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital timing controller of a dual-slope integrating converter. It divides the master clock into count ticks and runs a fixed-length measurement cycle in four phases: auto-zero, signal integrate, reference de-integrate and integrator zero. In each phase exactly one analog switch-control output is active. The analog integrator, its capacitors and its comparator sit outside the block. The only things that cross back are the comparator's zero-crossing signal, a polarity bit and a range select.

While the reference phase runs, a BCD counter advances once per tick. The phase ends on the first tick at which the comparator reports that the integrator has returned to zero, or when a hard count limit is reached. The counter value is the conversion result. The integrator-zero phase takes up whatever counts the reference phase left unused, so every cycle has the same length whatever the input. The result, its sign and an overrange flag are published together at the end of the cycle with a one-clock valid strobe. The range select cuts the integrate phase by a fixed divisor and changes no other phase.

Top module: `dsq_sequencer`

## Requirements
- R1: One count tick equals TICK_DIV clocks (default 2). All phase changes happen on tick edges, and one measurement cycle lasts TOTAL_COUNTS ticks (default 8000).
- R2: Exactly one of the five switch outputs is high on every clock. During reset and right after it, the auto-zero switch is the active one.
- R3: Auto-zero lasts AZ_COUNTS ticks (default 1500).
- R4: Signal integrate lasts INT_COUNTS ticks (default 2000) when range_hi is low and INT_COUNTS/RANGE_DIV ticks (default 200) when it is high. range_hi is sampled on the last auto-zero tick, and changes after that point have no effect on the cycle in progress.
- R5: The reference phase ends on the first tick at which comp_zero is high, counting that tick, so it lasts at least 1 tick. If comp_zero stays low it ends after FULL_SCALE+1 ticks (default 4001). comp_zero is ignored in every other phase.
- R6: pol_pos (1 = positive input) is sampled on the last integrate tick. A positive input selects sw_refneg during the reference phase and a negative input selects sw_refpos. result_neg is the inverse of the sampled pol_pos.
- R7: result_bcd equals the number of ticks spent in the reference phase, coded as packed BCD with four bits per digit and the least significant digit in bits 3:0.
- R8: overrange is 1 exactly when the reference phase ran to the FULL_SCALE+1 limit. The result then reads FULL_SCALE+1.
- R9: Integrator zero lasts TOTAL_COUNTS minus the auto-zero, integrate and reference lengths of the same cycle.
- R10: Phases run in the order auto-zero, integrate, reference, zero and then back to auto-zero. result_valid is high for exactly one clock, right after the last zero tick. result_bcd, result_neg and overrange change only on that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_hi | input | 1 | Selects the shortened integrate phase |
| pol_pos | input | 1 | Input polarity from the analog side, 1 = positive |
| comp_zero | input | 1 | Comparator reports that the integrator has crossed zero |
| sw_autozero | output | 1 | Auto-zero switch control |
| sw_integ | output | 1 | Signal-integrate switch control |
| sw_refpos | output | 1 | Positive-reference switch control |
| sw_refneg | output | 1 | Negative-reference switch control |
| sw_izero | output | 1 | Integrator-zero switch control |
| result_bcd | output | 4*DIGITS | Reference-phase count in packed BCD |
| result_neg | output | 1 | Sign of the result, 1 = negative input |
| overrange | output | 1 | Reference phase hit its count limit |
| result_valid | output | 1 | One-clock strobe when a new result is published |

## Verification
The assertions assume that the comparator, polarity and range inputs are synchronous to clk. They also assume that TICK_DIV is at least 2, so that each switch pattern holds for more than one clock. The stimulus changes all inputs only at falling clock edges. It holds range_hi steady through auto-zero and pol_pos steady through integrate, and randomises both outside those windows. comp_zero is randomised outside the reference phase. Inside that phase it is held low and then raised at a chosen count, or never raised. This exercises both the comparator exit and the limit exit without a glitch reaching the sampling edge.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   typedef enum logic [1:0] {
      PH_AZERO = 2'd0,
      PH_INTEG = 2'd1,
      PH_DEINT = 2'd2,
      PH_IZERO = 2'd3
   } dsq_phase_e;

   function automatic int bcd_capacity(input int digits);
      int cap;
      cap = 1;
      for (int i = 0; i < digits; i++) cap = cap * 10;
      return cap;
   endfunction

endpackage

// File: rtl/dsq_tick_gen.sv
module dsq_tick_gen #(
   parameter int TICK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int TW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam bit POW2 = ((1 << TW) == TICK_DIV);

   logic [TW-1:0] tcnt;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tcnt <= '0;
            else        tcnt <= tcnt + 1'b1;
         end
         assign tick = &tcnt;
      end else begin : g_cmp
         localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            tcnt <= '0;
            else if (tcnt == LAST) tcnt <= '0;
            else                   tcnt <= tcnt + 1'b1;
         end
         assign tick = (tcnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/dsq_bcd_count.sv
module dsq_bcd_count #(
   parameter int DIGITS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  inc,
   output logic [4*DIGITS-1:0]   q
);
   logic [DIGITS-1:0] carry;
   assign carry[0] = inc;

   generate
      for (genvar d = 0; d < DIGITS; d++) begin : g_dig
         logic [3:0] dig_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        dig_q <= 4'd0;
            else if (clr)      dig_q <= 4'd0;
            else if (carry[d]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
         end

         assign q[4*d +: 4] = dig_q;

         if (d < DIGITS - 1) begin : g_carry
            assign carry[d+1] = carry[d] && (dig_q == 4'd9);
         end
      end
   endgenerate

endmodule

// File: rtl/dsq_phase_ctrl.sv
module dsq_phase_ctrl
   import dsq_pkg::*;
#(
   parameter int AZ_COUNTS    = 1500,
   parameter int INT_COUNTS   = 2000,
   parameter int RANGE_DIV    = 10,
   parameter int FULL_SCALE   = 4000,
   parameter int TOTAL_COUNTS = 8000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       range_hi,
   input  logic       comp_zero,
   output dsq_phase_e phase,
   output logic       integ_done,
   output logic       deint_tick,
   output logic       deint_done,
   output logic       deint_at_limit,
   output logic       cycle_done
);
   localparam int CW        = $clog2(TOTAL_COUNTS);
   localparam int INT_SHORT = INT_COUNTS / RANGE_DIV;
   localparam int REF_MAX   = FULL_SCALE + 1;

   localparam logic [CW-1:0] AZ_LAST    = CW'(AZ_COUNTS - 1);
   localparam logic [CW-1:0] INT_LAST_L = CW'(INT_COUNTS - 1);
   localparam logic [CW-1:0] INT_LAST_S = CW'(INT_SHORT - 1);
   localparam logic [CW-1:0] REF_LAST   = CW'(REF_MAX - 1);
   localparam logic [CW-1:0] CYC_LAST   = CW'(TOTAL_COUNTS - 1);

   dsq_phase_e    phase_q;
   logic [CW-1:0] pcnt;
   logic [CW-1:0] cyc;
   logic          short_q;
   logic [CW-1:0] int_last;
   logic          az_end;

   assign int_last       = short_q ? INT_LAST_S : INT_LAST_L;
   assign az_end         = tick && (phase_q == PH_AZERO) && (pcnt == AZ_LAST);
   assign integ_done     = tick && (phase_q == PH_INTEG) && (pcnt == int_last);
   assign deint_tick     = tick && (phase_q == PH_DEINT);
   assign deint_at_limit = deint_tick && (pcnt == REF_LAST);
   assign deint_done     = deint_tick && (comp_zero || (pcnt == REF_LAST));
   assign cycle_done     = tick && (phase_q == PH_IZERO) && (cyc == CYC_LAST);
   assign phase          = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
      end else if (tick) begin
         cyc <= (cyc == CYC_LAST) ? '0 : cyc + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         short_q <= 1'b0;
      end else if (az_end) begin
         short_q <= range_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_AZERO;
         pcnt    <= '0;
      end else if (tick) begin
         unique case (phase_q)
            PH_AZERO: begin
               if (az_end) begin
                  phase_q <= PH_INTEG;
                  pcnt    <= '0;
               end else begin
                  pcnt <= pcnt + 1'b1;
               end
            end
            PH_INTEG: begin
               if (integ_done) begin
                  phase_q <= PH_DEINT;
                  pcnt    <= '0;
               end else begin
                  pcnt <= pcnt + 1'b1;
               end
            end
            PH_DEINT: begin
               if (deint_done) begin
                  phase_q <= PH_IZERO;
                  pcnt    <= '0;
               end else begin
                  pcnt <= pcnt + 1'b1;
               end
            end
            PH_IZERO: begin
               if (cycle_done) begin
                  phase_q <= PH_AZERO;
                  pcnt    <= '0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
   import dsq_pkg::*;
#(
   parameter int AZ_COUNTS    = 1500,
   parameter int INT_COUNTS   = 2000,
   parameter int RANGE_DIV    = 10,
   parameter int FULL_SCALE   = 4000,
   parameter int TOTAL_COUNTS = 8000,
   parameter int TICK_DIV     = 2,
   parameter int DIGITS       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                range_hi,
   input  logic                pol_pos,
   input  logic                comp_zero,
   output logic                sw_autozero,
   output logic                sw_integ,
   output logic                sw_refpos,
   output logic                sw_refneg,
   output logic                sw_izero,
   output logic [4*DIGITS-1:0] result_bcd,
   output logic                result_neg,
   output logic                overrange,
   output logic                result_valid
);
   localparam int REF_MAX  = FULL_SCALE + 1;
   localparam int BCD_CAP  = bcd_capacity(DIGITS);
   localparam int MIN_ZERO = TOTAL_COUNTS - AZ_COUNTS - INT_COUNTS - REF_MAX;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("dsq_sequencer: TICK_DIV must be at least 1");
      end
      if (RANGE_DIV < 1 || (INT_COUNTS % RANGE_DIV) != 0 || INT_COUNTS / RANGE_DIV < 1) begin : g_bad_range
         $error("dsq_sequencer: INT_COUNTS must split evenly by RANGE_DIV");
      end
      if (AZ_COUNTS < 1 || MIN_ZERO < 1) begin : g_bad_cycle
         $error("dsq_sequencer: phase budget exceeds TOTAL_COUNTS");
      end
      if (BCD_CAP <= REF_MAX) begin : g_bad_digits
         $error("dsq_sequencer: DIGITS too small for the reference limit");
      end
   endgenerate

   logic          tick;
   dsq_phase_e    phase;
   logic          integ_done;
   logic          deint_tick;
   logic          deint_done;
   logic          deint_at_limit;
   logic          cycle_done;
   logic [4*DIGITS-1:0] bcd_q;
   logic          pol_q;
   logic          ovr_pend;

   dsq_tick_gen #(
      .TICK_DIV (TICK_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dsq_phase_ctrl #(
      .AZ_COUNTS    (AZ_COUNTS),
      .INT_COUNTS   (INT_COUNTS),
      .RANGE_DIV    (RANGE_DIV),
      .FULL_SCALE   (FULL_SCALE),
      .TOTAL_COUNTS (TOTAL_COUNTS)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick           (tick),
      .range_hi       (range_hi),
      .comp_zero      (comp_zero),
      .phase          (phase),
      .integ_done     (integ_done),
      .deint_tick     (deint_tick),
      .deint_done     (deint_done),
      .deint_at_limit (deint_at_limit),
      .cycle_done     (cycle_done)
   );

   dsq_bcd_count #(
      .DIGITS (DIGITS)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (integ_done),
      .inc   (deint_tick),
      .q     (bcd_q)
   );

   // Polarity captured as integration closes; it steers the reference switch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pol_q <= 1'b1;
      else if (integ_done) pol_q <= pol_pos;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ovr_pend <= 1'b0;
      else if (deint_done) ovr_pend <= deint_at_limit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_bcd   <= '0;
         result_neg   <= 1'b0;
         overrange    <= 1'b0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= cycle_done;
         if (cycle_done) begin
            result_bcd <= bcd_q;
            result_neg <= ~pol_q;
            overrange  <= ovr_pend;
         end
      end
   end

   assign sw_autozero = (phase == PH_AZERO);
   assign sw_integ    = (phase == PH_INTEG);
   assign sw_refpos   = (phase == PH_DEINT) && !pol_q;
   assign sw_refneg   = (phase == PH_DEINT) &&  pol_q;
   assign sw_izero    = (phase == PH_IZERO);

endmodule

// File: rtl/dsq_sequencer_chk.sv
module dsq_sequencer_chk #(
   parameter int FULL_SCALE = 4000,
   parameter int TICK_DIV   = 2,
   parameter int DIGITS     = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sw_autozero,
   input logic                sw_integ,
   input logic                sw_refpos,
   input logic                sw_refneg,
   input logic                sw_izero,
   input logic [4*DIGITS-1:0] result_bcd,
   input logic                result_neg,
   input logic                overrange,
   input logic                result_valid
);
   function automatic logic [4*DIGITS-1:0] as_bcd(input int v);
      logic [4*DIGITS-1:0] r;
      int rem;
      r   = '0;
      rem = v;
      for (int i = 0; i < DIGITS; i++) begin
         r[4*i +: 4] = 4'(rem % 10);
         rem = rem / 10;
      end
      return r;
   endfunction

   function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   localparam logic [4*DIGITS-1:0] LIMIT_BCD = as_bcd(FULL_SCALE + 1);

   logic [4:0] sw_vec;
   assign sw_vec = {sw_autozero, sw_integ, sw_refpos, sw_refneg, sw_izero};

   AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sw_vec) == 1); // R2

   AST_TICK_PACE: assert property (@(posedge clk) disable iff (!rst_n)
      (TICK_DIV > 1) && !$stable(sw_vec) |=> $stable(sw_vec)); // R1

   AST_INT_AFTER_AZ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_integ) |-> $past(sw_autozero)); // R10

   AST_REF_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_refpos || sw_refneg) |-> $past(sw_integ)); // R10

   AST_AZ_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_autozero) |-> $past(sw_izero)); // R10

   AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R10

   AST_VALID_AT_AZ: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> sw_autozero); // R10

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable({result_bcd, result_neg, overrange})); // R10

   AST_OVR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      overrange |-> (result_bcd == LIMIT_BCD)); // R8

   AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> digits_ok(result_bcd)); // R7

endmodule

bind dsq_sequencer dsq_sequencer_chk #(
   .FULL_SCALE (FULL_SCALE),
   .TICK_DIV   (TICK_DIV),
   .DIGITS     (DIGITS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_autozero  (sw_autozero),
   .sw_integ     (sw_integ),
   .sw_refpos    (sw_refpos),
   .sw_refneg    (sw_refneg),
   .sw_izero     (sw_izero),
   .result_bcd   (result_bcd),
   .result_neg   (result_neg),
   .overrange    (overrange),
   .result_valid (result_valid)
);

// File: tb/dsq_sequencer_test.sv
module dsq_sequencer_test;
   localparam int AZ   = 15;
   localparam int INTC = 20;
   localparam int RDIV = 10;
   localparam int FS   = 40;
   localparam int TOT  = 80;
   localparam int TD   = 2;
   localparam int DG   = 4;
   localparam int RMAX = FS + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic range_hi = 1'b0;
   logic pol_pos = 1'b0;
   logic comp_zero = 1'b0;
   logic sw_autozero, sw_integ, sw_refpos, sw_refneg, sw_izero;
   logic [4*DG-1:0] result_bcd;
   logic result_neg, overrange, result_valid;

   dsq_sequencer #(
      .AZ_COUNTS (AZ), .INT_COUNTS (INTC), .RANGE_DIV (RDIV), .FULL_SCALE (FS),
      .TOTAL_COUNTS (TOT), .TICK_DIV (TD), .DIGITS (DG)
   ) uut (
      .clk (clk), .rst_n (rst_n), .range_hi (range_hi), .pol_pos (pol_pos),
      .comp_zero (comp_zero), .sw_autozero (sw_autozero), .sw_integ (sw_integ),
      .sw_refpos (sw_refpos), .sw_refneg (sw_refneg), .sw_izero (sw_izero),
      .result_bcd (result_bcd), .result_neg (result_neg), .overrange (overrange),
      .result_valid (result_valid)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int c_az, c_int, c_ref, c_zero, c_multi, c_wrongsw, c_drift, c_vwide, samples, ref_m;
   bit cur_r, cur_p, prev_valid, hung;
   int cur_n;
   logic [4*DG-1:0] last_res;
   logic last_neg, last_ovr;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [4*DG-1:0] to_bcd(input int v);
      logic [4*DG-1:0] r;
      int rem;
      r = '0;
      rem = v;
      for (int i = 0; i < DG; i++) begin
         r[4*i +: 4] = 4'(rem % 10);
         rem = rem / 10;
      end
      return r;
   endfunction

   // Sample outputs of this clock, then drive inputs for the next edge.
   task automatic tally_and_drive();
      bit in_ref;
      in_ref = sw_refpos || sw_refneg;
      if ($countones({sw_autozero, sw_integ, sw_refpos, sw_refneg, sw_izero}) != 1) c_multi++;
      if (sw_autozero) c_az++;
      if (sw_integ) c_int++;
      if (sw_izero) c_zero++;
      if (in_ref) begin
         c_ref++;
         ref_m++;
         if ((cur_p && sw_refpos) || (!cur_p && sw_refneg)) c_wrongsw++;
      end
      if (!result_valid && (result_bcd != last_res || result_neg != last_neg || overrange != last_ovr))
         c_drift++;
      if (prev_valid && result_valid) c_vwide++;
      prev_valid = result_valid;
      comp_zero = in_ref ? (cur_n <= RMAX && ref_m >= 2*cur_n - 1) : 1'($urandom % 2);
      range_hi  = sw_autozero ? cur_r : 1'($urandom % 2);
      pol_pos   = sw_integ ? cur_p : 1'($urandom % 2);
   endtask

   task automatic run_conv(input bit r, input bit p, input int n);
      int spent, ilen;
      bit first;
      c_az = 0; c_int = 0; c_ref = 0; c_zero = 0; c_multi = 0;
      c_wrongsw = 0; c_drift = 0; c_vwide = 0; samples = 0; ref_m = 0;
      cur_r = r; cur_p = p; cur_n = n;
      first = 1'b1;
      forever begin
         if (!first && result_valid) break;
         tally_and_drive();
         first = 1'b0;
         @(negedge clk);
         samples++;
         if (samples > 4 * TOT * TD) begin
            hung = 1'b1;
            check("R10", "watchdog: result_valid never came", 0, 1);
            break;
         end
      end
      if (hung) return;
      spent = (n >= RMAX) ? RMAX : n;
      ilen  = r ? INTC / RDIV : INTC;
      check("R1", "cycle clocks", samples, TD * TOT);
      check("R2", "clocks without exactly one switch", c_multi, 0);
      check("R3", "auto-zero clocks", c_az, TD * AZ);
      check("R4", "integrate clocks", c_int, TD * ilen);
      check("R5", "reference clocks", c_ref, TD * spent);
      check("R6", "clocks on wrong reference switch", c_wrongsw, 0);
      check("R6", "result_neg", result_neg, !p);
      check("R7", "result_bcd", result_bcd, to_bcd(spent));
      check("R8", "overrange", overrange, spent == RMAX);
      check("R9", "zero clocks", c_zero, TD * (TOT - AZ - ilen - spent));
      check("R10", "result change without valid", c_drift, 0);
      check("R10", "valid wider than one clock", c_vwide, 0);
      last_res = result_bcd;
      last_neg = result_neg;
      last_ovr = overrange;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      hung = 1'b0;
      prev_valid = 1'b0;
      last_res = '0;
      last_neg = 1'b0;
      last_ovr = 1'b0;
      cur_r = 1'b0; cur_p = 1'b1; cur_n = 1;
      repeat (3) @(negedge clk);
      // R2 reset state: auto-zero switch only, outputs cleared
      check("R2", "reset switch vector",
            {sw_autozero, sw_integ, sw_refpos, sw_refneg, sw_izero}, 5'b10000);
      check("R10", "reset valid/result",
            {result_valid, overrange, result_neg, result_bcd}, 0);
      rst_n = 1'b1;
      // directed corners: minimum count, full scale, limit hit, no comparator trip
      run_conv(1'b0, 1'b1, 1);
      if (!hung) run_conv(1'b0, 1'b0, FS);
      if (!hung) run_conv(1'b1, 1'b1, RMAX);
      if (!hung) run_conv(1'b1, 1'b0, RMAX + 3);
      if (!hung) run_conv(1'b0, 1'b1, 9);
      for (int k = 0; k < 200 && !hung; k++)
         run_conv(1'($urandom % 2), 1'($urandom % 2), $urandom_range(1, RMAX + 3));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule